// File: doc/BRIEF.md
# Parallel DAC Host Bus Sequencer

This block sits on the host side of a dual-channel, current-output converter that has a parallel data port. It takes a request naming a channel, a direction and a data word. It then performs the matching bus access: a strobe that loads a word into the converter's channel register, or one that reads the register back. Every interval on the bus is a whole number of system clock cycles. Each count is derived at elaboration from the clock period and the interval the converter requires, so no edge depends on routing delay.

A write request can also ask for verification. The block then follows the write with a read of the same channel and raises a mismatch flag if the word returned differs from the word written. The data bus is brought out as separate output, output-enable and input vectors, so the pad ring can build the tri-state driver.

Top module: `pdac_seq`

## Requirements
- R1: While reset is held low, `dac_cs_n` and `dac_rw` are high, `db_oe`, `done` and `mismatch` are low, and `req_ready` is high.
- R2: A write request (`req_rd`=0) loads `req_wdata` into the register of the channel given by `req_ch`, where 0 selects channel A and 1 selects channel B. The other channel's register is unchanged.
- R3: A read request (`req_rd`=1) returns the selected channel's register on `rd_data`. The value is valid while `done` is high and holds until the next read.
- R4: `dac_cs_n` stays low for LOW_CYC consecutive cycles. LOW_CYC is the largest of ceil(CS_LOW_PS/CLK_PS), ceil(ACCESS_PS/CLK_PS) and ceil(DATA_SU_PS/CLK_PS), which is 7 at the defaults. Read data is captured at the clock edge that ends the last low cycle.
- R5: `dac_ch` and `dac_rw` are set SU_CYC cycles before `dac_cs_n` falls. SU_CYC is the larger of ceil(ADDR_SU_PS/CLK_PS) and ceil(RW_CS_PS/CLK_PS), which is 3 at the defaults. Both signals stay stable until one cycle after `dac_cs_n` rises.
- R6: `db_oe` is high only during a write access: from setup through one cycle after `dac_cs_n` rises. It is never high while `dac_rw` is high, so the host never drives the bus while the converter does.
- R7: After each strobe, `dac_cs_n` stays high for at least 1+REC_CYC cycles. REC_CYC is the larger of ceil(RELINQ_PS/CLK_PS) and ceil(CS_HIGH_PS/CLK_PS), which is 3 at the defaults. This lets the converter release the bus after a read.
- R8: A write with `req_verify`=1 is followed by a read of the same channel. `mismatch` is high together with `done` exactly when the word read back differs from the word written. `mismatch` is never high without `done`. `req_verify` has no effect on a read.
- R9: `done` is a single-cycle pulse. It comes SU_CYC+LOW_CYC+1+REC_CYC cycles after the accepting edge (14 at the defaults), or twice that for a verified write (28).
- R10: `req_ready` is high only when the block is idle. A request raised while it is low is ignored: it changes no converter register and does not delay the current access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present; accepted when req_ready is high |
| req_ready | output | 1 | Block idle and able to accept |
| req_ch | input | 1 | Channel: 0 = A, 1 = B |
| req_rd | input | 1 | 1 = read back, 0 = write |
| req_verify | input | 1 | On a write, read back and compare |
| req_wdata | input | DW | Word to write |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DW | Last word read from the converter |
| mismatch | output | 1 | Verified write read back a different word (with done) |
| dac_ch | output | 1 | Channel select to the converter |
| dac_rw | output | 1 | 1 = read, 0 = write |
| dac_cs_n | output | 1 | Active-low strobe |
| db_o | output | DW | Data bus value driven by the host |
| db_oe | output | 1 | Host drives the data bus |
| db_i | input | DW | Data bus value seen by the host |

## Verification
On every cycle, the assertions check the minimum strobe low and high widths, the stability of channel and direction while the strobe is low, that the host never drives the bus during a read, and that `done` and `mismatch` are single-cycle pulses that arrive together. Some behaviour can only be shown by the bench's converter model, which returns wrong data until the access time has elapsed, keeps driving the bus after a read, and can corrupt a stored word on demand. That model is what shows correct data capture at the last low cycle, the absence of bus contention, the register contents after writes, verify mismatches, exact latency, and that requests made while busy are ignored.

// File: rtl/pdac_seq.sv
module pdac_seq #(
  parameter int DW         = 12,
  parameter int CLK_PS     = 4000,
  parameter int ADDR_SU_PS = 10000,
  parameter int RW_CS_PS   = 5000,
  parameter int CS_LOW_PS  = 10000,
  parameter int DATA_SU_PS = 6000,
  parameter int ACCESS_PS  = 25000,
  parameter int RELINQ_PS  = 10000,
  parameter int CS_HIGH_PS = 7000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_ch,
  input  logic          req_rd,
  input  logic          req_verify,
  input  logic [DW-1:0] req_wdata,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic          mismatch,
  output logic          dac_ch,
  output logic          dac_rw,
  output logic          dac_cs_n,
  output logic [DW-1:0] db_o,
  output logic          db_oe,
  input  logic [DW-1:0] db_i
);

  function automatic int cyc(input int ps);
    return (ps + CLK_PS - 1) / CLK_PS;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int SU_CYC  = imax(1, imax(cyc(ADDR_SU_PS), cyc(RW_CS_PS)));
  localparam int LOW_CYC = imax(1, imax(cyc(CS_LOW_PS), imax(cyc(ACCESS_PS), cyc(DATA_SU_PS))));
  localparam int REC_CYC = imax(1, imax(cyc(RELINQ_PS), cyc(CS_HIGH_PS)));
  localparam int CW      = $clog2(imax(SU_CYC, imax(LOW_CYC, REC_CYC)) + 1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_LOW, S_HIGH, S_REC, S_DONE} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          rd_q, vfy_q;
  logic [DW-1:0] wd_q;

  wire last = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      rd_q    <= 1'b1;
      vfy_q   <= 1'b0;
      wd_q    <= '0;
      dac_ch  <= 1'b0;
      rd_data <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          dac_ch <= req_ch;
          rd_q   <= req_rd;
          vfy_q  <= req_verify & ~req_rd;
          wd_q   <= req_wdata;
          cnt    <= CW'(SU_CYC - 1);
          st     <= S_SETUP;
        end
        S_SETUP: if (last) begin
          cnt <= CW'(LOW_CYC - 1);
          st  <= S_LOW;
        end else cnt <= cnt - 1'b1;
        S_LOW: if (last) begin
          if (rd_q) rd_data <= db_i;
          st <= S_HIGH;
        end else cnt <= cnt - 1'b1;
        S_HIGH: begin
          cnt <= CW'(REC_CYC - 1);
          st  <= S_REC;
        end
        S_REC: if (last) begin
          if (vfy_q && !rd_q) begin
            rd_q <= 1'b1;
            cnt  <= CW'(SU_CYC - 1);
            st   <= S_SETUP;
          end else st <= S_DONE;
        end else cnt <= cnt - 1'b1;
        S_DONE: begin
          rd_q <= 1'b1;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (st == S_IDLE);
  assign done      = (st == S_DONE);
  assign mismatch  = done && vfy_q && (rd_data != wd_q);
  assign dac_rw    = rd_q;
  assign dac_cs_n  = (st != S_LOW);
  assign db_o      = wd_q;
  assign db_oe     = !rd_q && (st == S_SETUP || st == S_LOW || st == S_HIGH);

endmodule

module pdac_seq_chk #(
  parameter int LOW_MIN  = 1,
  parameter int HIGH_MIN = 1
) (
  input logic clk,
  input logic rst_n,
  input logic dac_cs_n,
  input logic dac_rw,
  input logic dac_ch,
  input logic db_oe,
  input logic done,
  input logic mismatch
);
  logic [7:0] lowc, highc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lowc  <= '0;
      highc <= 8'hff;
    end else begin
      lowc  <= dac_cs_n ? '0 : ((lowc == 8'hff) ? lowc : lowc + 1'b1);
      highc <= !dac_cs_n ? '0 : ((highc == 8'hff) ? highc : highc + 1'b1);
    end
  end

  // R4
  cs_low_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_cs_n) |-> (lowc >= 8'(LOW_MIN)));
  // R7
  cs_high_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dac_cs_n) |-> (highc >= 8'(HIGH_MIN)));
  // R5
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dac_cs_n && $past(!dac_cs_n)) |-> ($stable(dac_ch) && $stable(dac_rw)));
  // R6
  no_drive_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    db_oe |-> !dac_rw);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  mismatch_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |-> done);
endmodule

bind pdac_seq pdac_seq_chk #(.LOW_MIN(LOW_CYC), .HIGH_MIN(REC_CYC + 1)) u_chk (
  .clk(clk), .rst_n(rst_n), .dac_cs_n(dac_cs_n), .dac_rw(dac_rw), .dac_ch(dac_ch),
  .db_oe(db_oe), .done(done), .mismatch(mismatch));

// File: tb/pdac_seq_tb.sv
module pdac_seq_tb;
  localparam int DW = 12;
  localparam int TCK = 4000;
  localparam int SU  = 3;   // max(ceil(10/4), ceil(5/4))
  localparam int LOW = 7;   // max(ceil(10/4), ceil(25/4), ceil(6/4))
  localparam int REC = 3;   // max(ceil(10/4), ceil(7/4))
  localparam int LAT = SU + LOW + 1 + REC;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ch = 0, req_rd = 0, req_verify = 0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, done, mismatch, dac_ch, dac_rw, dac_cs_n, db_oe;
  logic [DW-1:0] rd_data, db_o, db_i;

  int checks = 0, errors = 0, cycles = 0;

  always #2 clk = ~clk;

  pdac_seq u_dut (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_ch(req_ch), .req_rd(req_rd), .req_verify(req_verify), .req_wdata(req_wdata),
    .done(done), .rd_data(rd_data), .mismatch(mismatch), .dac_ch(dac_ch), .dac_rw(dac_rw),
    .dac_cs_n(dac_cs_n), .db_o(db_o), .db_oe(db_oe), .db_i(db_i));

  // converter model
  logic [DW-1:0] mem [2];
  logic [DW-1:0] corrupt = '0;
  int lowcnt = 0, relq = 0;
  wire m_oe = (!dac_cs_n && dac_rw) || relq != 0;
  assign db_i = m_oe ? ((lowcnt >= LOW - 1 && !dac_cs_n) ? mem[dac_ch] : ~mem[dac_ch]) : '0;

  always @(posedge clk) begin
    lowcnt <= dac_cs_n ? 0 : lowcnt + 1;
    if (!dac_cs_n && dac_rw) relq <= 2;
    else if (relq > 0) relq <= relq - 1;
    if (!dac_cs_n && !dac_rw) mem[dac_ch] <= db_o ^ corrupt;
  end

  logic [DW-1:0] exp_mem [2];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // contention watch on every cycle
  always @(negedge clk) if (rst_n) begin
    if (db_oe && m_oe) begin
      errors++;
      $display("FAIL R6 actual=%0h expected=%0h", 1, 0);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic op(input bit ch, input int kind, input logic [DW-1:0] d, input bit poke);
    int n;
    bit exp_mm;
    @(negedge clk);
    chk(req_ready, "R10 ready when idle", req_ready, 1);
    req_valid = 1; req_ch = ch; req_rd = (kind == 1); req_verify = (kind == 2); req_wdata = d;
    @(posedge clk);
    n = 0;
    forever begin
      @(negedge clk);
      req_valid = 0;
      if (done) break;
      n++;
      if (poke && n == 3) begin
        chk(!req_ready, "R10 busy", req_ready, 0);
        req_valid = 1; req_ch = ~ch; req_rd = 0; req_verify = 0; req_wdata = ~d;
      end
      if (n > 200) break;
    end
    chk(n == ((kind == 2) ? 2 * LAT : LAT), "R9 latency", n, (kind == 2) ? 2 * LAT : LAT);
    exp_mm = 0;
    if (kind != 1) begin
      exp_mem[ch] = d ^ corrupt;
      exp_mm = (kind == 2) && (corrupt != 0);
    end
    if (kind != 0) chk(rd_data == exp_mem[ch], "R3 read data", rd_data, exp_mem[ch]);
    chk(mismatch == exp_mm, "R8 mismatch", mismatch, exp_mm);
    @(negedge clk);
    chk(!done, "R9 done pulse", done, 0);
    chk(mem[0] == exp_mem[0] && mem[1] == exp_mem[1], "R2 registers", {mem[1], mem[0]}, {exp_mem[1], exp_mem[0]});
  endtask

  initial begin
    mem[0] = '0; mem[1] = '0; exp_mem[0] = '0; exp_mem[1] = '0;
    void'($urandom(32'h1234));
    repeat (3) @(negedge clk);
    chk(dac_cs_n && dac_rw && !db_oe && !done && !mismatch && req_ready, "R1 reset",
        {dac_cs_n, dac_rw, db_oe, done, mismatch, req_ready}, 6'b110001);
    rst_n = 1;
    op(0, 0, 12'hABC, 0);
    op(1, 0, 12'h123, 0);
    op(0, 1, '0, 0);               // R4: model returns inverted data before access time
    op(1, 1, '0, 0);
    op(0, 0, 12'hFFF, 1);          // R10: request raised while busy is ignored
    op(1, 1, '0, 0);
    op(1, 2, 12'h5A5, 0);          // R8 verify pass
    corrupt = 12'h010;
    op(0, 2, 12'h0F0, 0);          // R8 verify fail
    corrupt = '0;
    op(0, 1, '0, 1);
    op(1, 1, 12'h000, 0);
    op(0, 2, 12'h000, 0);
    for (int i = 0; i < 40; i++) begin
      op(1'($urandom), int'($urandom % 3), DW'($urandom), 1'($urandom % 4 == 0));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule